// File: doc/BRIEF.md
# Vertical-Blanking Data Line Inserter

This block places three kinds of host-supplied ancillary payload into the vertical blanking interval as a digital bit stream: caption characters and copy-generation control words for 525-line systems, and the aspect-ratio signalling word for 625-line systems. The host writes the payloads, per-service enables, a standard select and one bit-rate divider per service through a small write-only register port. The block computes each service's check bits itself. These are an odd-parity bit per caption character and a 6-bit CRC on the copy-control word.

A timing generator supplies a line-start strobe together with the current line number and the field. A field-start strobe marks the point where newly written settings become active. On a matching line the block emits a data-valid flag and one bit level per clock. Each element is held for a programmable number of clocks. A later stage converts the stream to luma levels.

Top module: `vbi_data_inserter`

## Requirements
- R1: After reset, data_valid and bit_level are low, every service is disabled, the 525-line standard is selected and nothing is emitted on any line.
- R2: In 525 mode with captions enabled, a line_start on line 21 in field one (field_two=0) emits the field-one caption word, and line 284 in field two emits the field-two word. Captions are emitted on no other line or field.
- R3: A caption frame has 26 elements in this order: preamble 1,0,1,0,1,0,1,0,0,1, then the first character (7 bits, LSB first) and its parity bit, then the second character and its parity bit. The parity bit makes each 8-bit group hold an odd number of ones.
- R4: In 525 mode with the copy-control service enabled, line 20 of field one and line 283 of field two each carry 20 elements. The first 14 are payload bits 0..13 in order. The last 6 are the CRC, most significant bit first. The CRC uses generator x^6+x+1, starts from all ones and covers the 14 payload bits in transmitted order.
- R5: In 625 mode with the aspect service enabled, only line 23 of field one carries 42 elements. These are run-in 1,0,1,0,1,0,1,0, then start code 0,0,0,1,1,1, then each word bit 0..13 as the pair (b, not b).
- R6: In 625 mode, captions and copy-control words are never emitted. In 525 mode, the aspect word is never emitted.
- R7: A disabled service leaves its line idle: data_valid and bit_level stay low.
- R8: Register writes land in a pending copy. They affect emitted lines only after the next field_start pulse.
- R9: Every element lasts D+1 clocks, where D is the active divider of the service being sent. Each service has its own divider.
- R10: data_valid rises in the clock after an accepted line_start, stays high for exactly the frame length times D+1 clocks and is otherwise low. A line_start during a frame is ignored.
- R11: Register addresses: 0 control (bit0 caption enable, bit1 copy-control enable, bit2 aspect enable, bit3 625 select); 1 field-one caption (bits 6:0 first character, 13:7 second); 2 field-two caption; 3 copy-control payload bits 13:0; 4 aspect word bits 13:0; 5, 6, 7 dividers for caption, copy-control and aspect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 14 | Register write data |
| field_start | input | 1 | Pulse that activates pending settings |
| line_start | input | 1 | Pulse marking the start of a line |
| line_num | input | 10 | Current line number |
| field_two | input | 1 | 0 for field one, 1 for field two |
| data_valid | output | 1 | Ancillary element being driven |
| bit_level | output | 1 | Level of the current element |

## Verification
The assertions assume that line_num, field_two and the standard select stay constant while a frame is being sent. They also assume that field_start does not arrive in the middle of a frame. The bench drives a new line number, field or field_start only after the observation window of the previous line has ended, and every window is longer than the frame it watches. Within those limits, the bench sweeps character, payload and word values together with several divider settings. It also probes the wrong lines, the wrong fields and the wrong standard.

// File: rtl/vbi_data_inserter.sv
module vbi_data_inserter #(
  parameter int DIVW     = 8,
  parameter int CC_DIV   = 53,
  parameter int CGMS_DIV = 59,
  parameter int WSS_DIV  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [13:0] wr_data,
  input  logic        field_start,
  input  logic        line_start,
  input  logic [9:0]  line_num,
  input  logic        field_two,
  output logic        data_valid,
  output logic        bit_level
);
  localparam int FRW = 42;
  localparam int LENW = 6;
  localparam logic [9:0] LN_CC1 = 10'd21,  LN_CC2 = 10'd284;
  localparam logic [9:0] LN_CG1 = 10'd20,  LN_CG2 = 10'd283;
  localparam logic [9:0] LN_WS  = 10'd23;
  localparam logic [LENW-1:0] LEN_CC = 6'd26, LEN_CG = 6'd20, LEN_WS = 6'd42;

  logic [3:0]      ctl_p, ctl_a;
  logic [13:0]     cc1_p, cc1_a, cc2_p, cc2_a, cg_p, cg_a, ws_p, ws_a;
  logic [DIVW-1:0] dcc_p, dcc_a, dcg_p, dcg_a, dws_p, dws_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_p <= '0; cc1_p <= '0; cc2_p <= '0; cg_p <= '0; ws_p <= '0;
      dcc_p <= DIVW'(CC_DIV); dcg_p <= DIVW'(CGMS_DIV); dws_p <= DIVW'(WSS_DIV);
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: ctl_p <= wr_data[3:0];
        3'd1: cc1_p <= wr_data;
        3'd2: cc2_p <= wr_data;
        3'd3: cg_p  <= wr_data;
        3'd4: ws_p  <= wr_data;
        3'd5: dcc_p <= wr_data[DIVW-1:0];
        3'd6: dcg_p <= wr_data[DIVW-1:0];
        default: dws_p <= wr_data[DIVW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a <= '0; cc1_a <= '0; cc2_a <= '0; cg_a <= '0; ws_a <= '0;
      dcc_a <= DIVW'(CC_DIV); dcg_a <= DIVW'(CGMS_DIV); dws_a <= DIVW'(WSS_DIV);
    end else if (field_start) begin
      ctl_a <= ctl_p; cc1_a <= cc1_p; cc2_a <= cc2_p; cg_a <= cg_p; ws_a <= ws_p;
      dcc_a <= dcc_p; dcg_a <= dcg_p; dws_a <= dws_p;
    end
  end

  wire is625 = ctl_a[3];
  wire [13:0] cc_sel = field_two ? cc2_a : cc1_a;

  logic [FRW-1:0] cc_frame, cg_frame, ws_frame;
  logic [5:0] crc;

  assign cc_frame = {16'b0, ~^cc_sel[13:7], cc_sel[13:7], ~^cc_sel[6:0], cc_sel[6:0],
                     10'b1001010101};

  always_comb begin
    logic fb;
    crc = 6'h3F;
    for (int i = 0; i < 14; i++) begin
      fb  = cg_a[i] ^ crc[5];
      crc = {crc[4:0], fb} ^ {4'b0, fb, 1'b0};
    end
    cg_frame = '0;
    cg_frame[13:0] = cg_a;
    for (int k = 0; k < 6; k++) cg_frame[14+k] = crc[5-k];
  end

  always_comb begin
    ws_frame = '0;
    ws_frame[13:0] = {6'b111000, 8'b01010101};
    for (int j = 0; j < 14; j++) begin
      ws_frame[14+2*j] = ws_a[j];
      ws_frame[15+2*j] = ~ws_a[j];
    end
  end

  wire cc_hit = ctl_a[0] & ~is625 &
                ((~field_two & (line_num == LN_CC1)) | (field_two & (line_num == LN_CC2)));
  wire cg_hit = ctl_a[1] & ~is625 &
                ((~field_two & (line_num == LN_CG1)) | (field_two & (line_num == LN_CG2)));
  wire ws_hit = ctl_a[2] & is625 & ~field_two & (line_num == LN_WS);

  logic            busy;
  logic [FRW-1:0]  frame;
  logic [LENW-1:0] remain;
  logic [DIVW-1:0] dcnt, dcur;

  wire load = line_start & ~busy & (cc_hit | cg_hit | ws_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '0; remain <= '0; dcnt <= '0; dcur <= '0;
    end else if (load) begin
      busy <= 1'b1;
      dcnt <= '0;
      if (cc_hit) begin
        frame <= cc_frame; remain <= LEN_CC; dcur <= dcc_a;
      end else if (cg_hit) begin
        frame <= cg_frame; remain <= LEN_CG; dcur <= dcg_a;
      end else begin
        frame <= ws_frame; remain <= LEN_WS; dcur <= dws_a;
      end
    end else if (busy) begin
      if (dcnt == dcur) begin
        dcnt   <= '0;
        frame  <= frame >> 1;
        remain <= remain - 1'b1;
        if (remain == 6'd1) busy <= 1'b0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end
  end

  assign data_valid = busy;
  assign bit_level  = busy & frame[0];

  // R10
  line_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (line_num == LN_CC1 || line_num == LN_CC2 || line_num == LN_CG1 ||
                    line_num == LN_CG2 || line_num == LN_WS));

  // R6
  std625_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && is625) |-> (line_num == LN_WS && !field_two));

  // R10
  start_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(line_start));

  // R9
  element_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && dcnt != '0) |-> $stable(bit_level));

  // R7
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(ctl_a[2:0] != 3'b000));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> !bit_level);
endmodule

// File: tb/test_vbi_data_inserter.sv
module test_vbi_data_inserter;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, field_start = 1'b0, line_start = 1'b0;
  logic field_two = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [13:0] wr_data = '0;
  logic [9:0]  line_num = '0;
  logic data_valid, bit_level;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vbi_data_inserter i_vbi_data_inserter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .field_start(field_start), .line_start(line_start), .line_num(line_num),
    .field_two(field_two), .data_valid(data_valid), .bit_level(bit_level));

  function automatic logic [41:0] cc_exp(input logic [6:0] a, input logic [6:0] b);
    logic [41:0] f = '0;
    int ones;
    bit pre [10] = '{1,0,1,0,1,0,1,0,0,1};
    for (int i = 0; i < 10; i++) f[i] = pre[i];
    ones = 0;
    for (int i = 0; i < 7; i++) begin f[10+i] = a[i]; ones += a[i]; end
    f[17] = (ones % 2 == 0);
    ones = 0;
    for (int i = 0; i < 7; i++) begin f[18+i] = b[i]; ones += b[i]; end
    f[25] = (ones % 2 == 0);
    return f;
  endfunction

  function automatic logic [41:0] cg_exp(input logic [13:0] p);
    logic [19:0] v = '0;
    logic [41:0] f = '0;
    for (int i = 0; i < 14; i++) v[19-i] = p[i];
    v[19:14] = v[19:14] ^ 6'h3F;
    for (int k = 19; k >= 6; k--) if (v[k]) v[k -: 7] = v[k -: 7] ^ 7'b1000011;
    f[13:0] = p;
    for (int k = 0; k < 6; k++) f[14+k] = v[5-k];
    return f;
  endfunction

  function automatic logic [41:0] ws_exp(input logic [13:0] w);
    logic [41:0] f = '0;
    bit hdr [14] = '{1,0,1,0,1,0,1,0,0,0,0,1,1,1};
    for (int i = 0; i < 14; i++) f[i] = hdr[i];
    for (int j = 0; j < 14; j++) begin f[14+2*j] = w[j]; f[15+2*j] = !w[j]; end
    return f;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 14'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic new_field();
    @(negedge clk); field_start = 1'b1;
    @(negedge clk); field_start = 1'b0;
  endtask

  task automatic run_line(input bit fld, input int ln, input int len,
                          input logic [41:0] fr, input int dv, input string tag);
    int per = dv + 1;
    int total = (len == 0) ? 60 : len * per + 3;
    int bad = 0, at = 0;
    logic ev, el, gv, gl;
    @(negedge clk); line_num = 10'(ln); field_two = fld; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    for (int c = 0; c < total; c++) begin
      ev = (c < len * per);
      el = ev ? fr[c / per] : 1'b0;
      if (data_valid !== ev || bit_level !== el) begin
        if (bad == 0) begin at = c; gv = data_valid; gl = bit_level; end
        bad++;
        if (bad == 1) begin
          $display("FAIL %s line %0d cycle %0d: valid/level=%b%b expected %b%b",
                   tag, ln, at, gv, gl, ev, el);
        end
      end
      @(negedge clk);
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [6:0] a, b, c2, d2;
    logic [13:0] p;
    repeat (3) @(negedge clk);
    checks++;
    if (data_valid !== 1'b0 || bit_level !== 1'b0) begin
      errors++; $display("FAIL R1 in reset: %b%b expected 00", data_valid, bit_level);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (data_valid !== 1'b0 || bit_level !== 1'b0) begin
      errors++; $display("FAIL R1 after reset: %b%b expected 00", data_valid, bit_level);
    end
    run_line(0, 21, 0, '0, 0, "R1 caption line idle");
    run_line(0, 20, 0, '0, 0, "R1 copy line idle");

    // R2 R3 R9 R11: caption sweep over dividers and characters
    for (int dv = 0; dv < 3; dv++) begin
      for (int i = 0; i < 12; i++) begin
        a = 7'(i * 37 + dv * 11); b = 7'(~(i * 19) + dv);
        c2 = 7'(i * 53 + 5); d2 = 7'(127 - i * 9);
        wr(0, 1); wr(5, dv); wr(1, {b, a}); wr(2, {d2, c2});
        new_field();
        run_line(0, 21, 26, cc_exp(a, b), dv, "R2 R3 caption field one");
        run_line(1, 284, 26, cc_exp(c2, d2), dv, "R2 R3 caption field two");
      end
    end
    run_line(1, 21, 0, '0, 0, "R2 line 21 in field two");
    run_line(0, 284, 0, '0, 0, "R2 line 284 in field one");
    run_line(0, 22, 0, '0, 0, "R2 neighbour line");

    // R8: pending write without field_start keeps old frame
    wr(1, {7'h55, 7'h2A});
    run_line(0, 21, 26, cc_exp(a, b), 2, "R8 before field start");
    new_field();
    run_line(0, 21, 26, cc_exp(7'h2A, 7'h55), 2, "R8 after field start");

    // R4 R9: copy-control sweep with its own divider
    for (int i = 0; i < 24; i++) begin
      p = (i == 0) ? 14'h0000 : (i == 1) ? 14'h3FFF : 14'(i * 1777 ^ (i << 9));
      wr(0, 3); wr(6, i % 4); wr(3, p);
      new_field();
      run_line(0, 20, 20, cg_exp(p), i % 4, "R4 copy-control field one");
      run_line(1, 283, 20, cg_exp(p), i % 4, "R4 copy-control field two");
      run_line(0, 21, 26, cc_exp(7'h2A, 7'h55), 2, "R9 caption divider kept");
    end
    run_line(0, 23, 0, '0, 0, "R6 aspect line in 525 mode");

    // R7: disabled services stay idle
    wr(0, 0); new_field();
    run_line(0, 21, 0, '0, 0, "R7 caption disabled");
    run_line(0, 20, 0, '0, 0, "R7 copy-control disabled");
    wr(0, 1); new_field();
    run_line(0, 20, 0, '0, 0, "R7 copy-control off, caption on");

    // R5 R6: 625 mode
    for (int i = 0; i < 24; i++) begin
      p = (i == 0) ? 14'h0000 : (i == 1) ? 14'h3FFF : 14'(i * 911 + (i << 6));
      wr(0, 15); wr(7, i % 3); wr(4, p);
      new_field();
      run_line(0, 23, 42, ws_exp(p), i % 3, "R5 aspect word");
    end
    run_line(1, 23, 0, '0, 0, "R5 line 23 field two");
    run_line(0, 21, 0, '0, 0, "R6 caption in 625 mode");
    run_line(0, 20, 0, '0, 0, "R6 copy-control in 625 mode");
    run_line(1, 283, 0, '0, 0, "R6 copy-control field two in 625 mode");
    wr(0, 11); new_field();
    run_line(0, 23, 0, '0, 0, "R7 aspect disabled");

    // R10: second line_start mid-frame ignored
    wr(0, 1); wr(5, 1); new_field();
    @(negedge clk); line_num = 10'd21; field_two = 1'b0; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (10) @(negedge clk);
    line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    repeat (40) @(negedge clk);
    checks++;
    if (data_valid !== 1'b1) begin
      errors++; $display("FAIL R10 mid-frame restart: valid=%b expected 1", data_valid);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (data_valid !== 1'b0) begin
      errors++; $display("FAIL R10 frame end: valid=%b expected 0", data_valid);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule